// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two bidirectional buses, called A and B, through a set of independent lanes, each eight bits wide by default. Two lanes make the default sixteen-bit unit. Every lane holds two storage registers, one for each direction of travel. An active-low enable, a direction bit and two source selects decide which bus the lane drives. The driven bus can carry the live value of the opposite bus or the value held in the register. When a lane's enable is off, both of its buses float, but both registers can still be loaded. Data can therefore be taken while the lane is isolated and put onto a bus later.

The buses are modelled as separate input, output and per-lane output-enable vectors, so they can be synthesised; a board-level wrapper joins them on tri-state nets. Each capture strobe is sampled on the system clock `clk`. A register loads when its strobe is seen low at one clock edge and high at the next. A synchronous active-low reset clears every register. If several lanes are driven from the same controls, they act as one wider transceiver.

Top module: `reg_bus_xcvr`

## Requirements
- R1: When `rst_n` is low at a clock edge, every lane's two registers become zero and each strobe history is set to "high". A strobe that is held high through reset and after it therefore causes no capture until it has gone low and then high again.
- R2: Consider a clock edge where a lane's `cap_ab` bit was 0 at the previous edge and is 1 now. At that edge the lane's A-to-B register loads the lane's A-side value. A strobe held high loads nothing more.
- R3: The B-to-A register loads the lane's B-side value under the same rising-strobe rule, using `cap_ba`. It is independent of R2, and both registers may load at the same edge.
- R4: When `oe_n` bit h is 1, `a_oe[h]` and `b_oe[h]` are 0 and the lane's `a_out` and `b_out` bits read zero. Both registers still load per R2 and R3.
- R5: When `oe_n`=0 and `dir`=0, `a_oe`=1 and `b_oe`=0. `a_out` equals the lane's `b_in` when `sel_ba`=0, and the B-to-A register when `sel_ba`=1. `b_out` reads zero.
- R6: When `oe_n`=0 and `dir`=1, `b_oe`=1 and `a_oe`=0. `b_out` equals the lane's `a_in` when `sel_ab`=0, and the A-to-B register when `sel_ab`=1. `a_out` reads zero.
- R7: `a_oe[h]` and `b_oe[h]` are never 1 together.
- R8: Lane h occupies data bits [8h+7:8h] of every bus vector and uses only bit h of each control vector. Lanes do not affect each other.
- R9: When a register loads while the lane drives that register's own bus, it stores the driven value (`a_out` or `b_out` of that lane) and ignores `a_in` or `b_in`.
- R10: Each output bit comes from a single two-way choice between the live source and the stored source. An enabled output with the live source selected always equals the opposite bus input, with no other value in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; capture strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| oe_n | input | 2 | Per-lane active-low output enable |
| dir | input | 2 | Per-lane direction: 0 drives A, 1 drives B |
| cap_ab | input | 2 | Per-lane A-to-B capture strobe |
| cap_ba | input | 2 | Per-lane B-to-A capture strobe |
| sel_ab | input | 2 | Per-lane B source: 0 live A, 1 stored |
| sel_ba | input | 2 | Per-lane A source: 0 live B, 1 stored |
| a_in | input | 16 | Values present on bus A |
| a_out | output | 16 | Value the block drives onto bus A |
| a_oe | output | 2 | Per-lane drive enable for bus A |
| b_in | input | 16 | Values present on bus B |
| b_out | output | 16 | Value the block drives onto bus B |
| b_oe | output | 2 | Per-lane drive enable for bus B |

## Verification
The registers can only be seen through the stored-source path. A wrong captured value, a missed capture or an extra capture therefore shows up on `b_out` or `a_out` the first time that lane is enabled towards the opposite bus with the stored select. In the random mix that happens within a few cycles. The bench checks every output of every lane half a cycle after each edge. A bad enable or live-path decode shows up in the same cycle as the control change that exposes it. A spurious reload shows up as a stored output that moves while its strobe stayed low.

// File: rtl/xcvr_pkg.sv
// Shared types for the registered bus transceiver.
// Assumes: one control bundle per lane, all fields sampled on the system clock.
package xcvr_pkg;
    typedef struct packed {
        logic oe_n;
        logic dir;
        logic cap_ab;
        logic cap_ba;
        logic sel_ab;
        logic sel_ba;
    } lane_ctl_t;
endpackage

// File: rtl/xcvr_cap_reg.sv
// Edge-strobed storage register.
// Loads d at a clock edge where strobe was low at the prior edge and is high now.
// Assumes: strobe is synchronous to clk; reset marks the strobe history high.
module xcvr_cap_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic strobe_q;

    // Track strobe history and load on a detected rising strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b1;
            q        <= '0;
        end else begin
            strobe_q <= strobe;
            if (strobe && !strobe_q)
                q <= d;
        end
    end
endmodule

// File: rtl/xcvr_lane.sv
// One transceiver lane: two direction registers, source selects, drive enables.
// Assumes: at most one side driven; a driven side captures its own driven value.
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  lane_ctl_t    ctl,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] b_out,
    output logic         a_oe,
    output logic         b_oe
);
    logic         drv_a, drv_b;
    logic [W-1:0] st_ab, st_ba;
    logic [W-1:0] a_side, b_side;

    // Decode which side this lane drives.
    always_comb begin
        drv_a = !ctl.oe_n && !ctl.dir;
        drv_b = !ctl.oe_n &&  ctl.dir;
    end

    // Single two-way choice per output bit, then gate by the drive enable.
    always_comb begin
        a_out = drv_a ? (ctl.sel_ba ? st_ba : b_in) : '0;
        b_out = drv_b ? (ctl.sel_ab ? st_ab : a_in) : '0;
        a_oe  = drv_a;
        b_oe  = drv_b;
    end

    // Value present on each bus: the driven value when this lane drives it.
    always_comb begin
        a_side = drv_a ? a_out : a_in;
        b_side = drv_b ? b_out : b_in;
    end

    xcvr_cap_reg #(.W(W)) u_ab (
        .clk(clk), .rst_n(rst_n), .strobe(ctl.cap_ab), .d(a_side), .q(st_ab)
    );

    xcvr_cap_reg #(.W(W)) u_ba (
        .clk(clk), .rst_n(rst_n), .strobe(ctl.cap_ba), .d(b_side), .q(st_ba)
    );
endmodule

// File: rtl/reg_bus_xcvr.sv
// Registered bidirectional bus transceiver, LANES independent lanes of LANE_W bits.
// Assumes: bidirectional buses are split into in/out/enable; wrapper builds tri nets.
module reg_bus_xcvr
    import xcvr_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int LANES  = 2,
    localparam int BUS_W = LANE_W * LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] oe_n,
    input  logic [LANES-1:0] dir,
    input  logic [LANES-1:0] cap_ab,
    input  logic [LANES-1:0] cap_ba,
    input  logic [LANES-1:0] sel_ab,
    input  logic [LANES-1:0] sel_ba,
    input  logic [BUS_W-1:0] a_in,
    output logic [BUS_W-1:0] a_out,
    output logic [LANES-1:0] a_oe,
    input  logic [BUS_W-1:0] b_in,
    output logic [BUS_W-1:0] b_out,
    output logic [LANES-1:0] b_oe
);
    for (genvar h = 0; h < LANES; h++) begin : g_lane
        lane_ctl_t ctl;

        // Bundle this lane's control bits.
        always_comb begin
            ctl = '{oe_n: oe_n[h], dir: dir[h], cap_ab: cap_ab[h],
                    cap_ba: cap_ba[h], sel_ab: sel_ab[h], sel_ba: sel_ba[h]};
        end

        xcvr_lane #(.W(LANE_W)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .ctl   (ctl),
            .a_in  (a_in[h*LANE_W +: LANE_W]),
            .b_in  (b_in[h*LANE_W +: LANE_W]),
            .a_out (a_out[h*LANE_W +: LANE_W]),
            .b_out (b_out[h*LANE_W +: LANE_W]),
            .a_oe  (a_oe[h]),
            .b_oe  (b_oe[h])
        );
    end
endmodule

// File: rtl/reg_bus_xcvr_chk.sv
// Port-level checker for reg_bus_xcvr, attached by bind.
// Assumes: observes only top-level ports.
module reg_bus_xcvr_chk #(
    parameter int LANE_W = 8,
    parameter int LANES  = 2,
    localparam int BUS_W = LANE_W * LANES
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LANES-1:0] oe_n,
    input logic [LANES-1:0] dir,
    input logic [LANES-1:0] cap_ab,
    input logic [LANES-1:0] cap_ba,
    input logic [LANES-1:0] sel_ab,
    input logic [LANES-1:0] sel_ba,
    input logic [BUS_W-1:0] a_in,
    input logic [BUS_W-1:0] a_out,
    input logic [LANES-1:0] a_oe,
    input logic [BUS_W-1:0] b_in,
    input logic [BUS_W-1:0] b_out,
    input logic [LANES-1:0] b_oe
);
    logic live;

    // Mark one full clock out of reset so $past never reaches pre-reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) live <= 1'b0;
        else        live <= 1'b1;
    end

    for (genvar h = 0; h < LANES; h++) begin : g_chk
        p_one_side_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !(a_oe[h] && b_oe[h]));

        p_isolate_r4: assert property (@(posedge clk) disable iff (!rst_n)
            oe_n[h] |-> (!a_oe[h] && !b_oe[h]));

        p_quiet_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !a_oe[h] |-> (a_out[h*LANE_W +: LANE_W] == '0));

        p_live_a_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (a_oe[h] && !sel_ba[h]) |->
                (a_out[h*LANE_W +: LANE_W] == b_in[h*LANE_W +: LANE_W]));

        p_live_b_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (b_oe[h] && !sel_ab[h]) |->
                (b_out[h*LANE_W +: LANE_W] == a_in[h*LANE_W +: LANE_W]));

        // R2: with no strobe at the last edge, a stored value on B does not move.
        p_hold_ab_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (live && !$past(cap_ab[h]) && b_oe[h] && sel_ab[h]
                  && $past(b_oe[h]) && $past(sel_ab[h]))
            |-> $stable(b_out[h*LANE_W +: LANE_W]));
    end
endmodule

bind reg_bus_xcvr reg_bus_xcvr_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (.*);

// File: tb/tb_reg_bus_xcvr.sv
`timescale 1ns/1ps
module tb_reg_bus_xcvr;
    localparam int HW = 8;
    localparam int NL = 2;
    localparam int BW = HW * NL;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NL-1:0] oe_n, dir, cap_ab, cap_ba, sel_ab, sel_ba;
    logic [BW-1:0] a_in, b_in;
    logic [BW-1:0] a_out, b_out;
    logic [NL-1:0] a_oe, b_oe;

    int total = 0;
    int fails = 0;

    logic [HW-1:0] m_ab [NL];
    logic [HW-1:0] m_ba [NL];
    logic          p_ab [NL];
    logic          p_ba [NL];

    always #4 clk = ~clk;

    reg_bus_xcvr #(.LANE_W(HW), .LANES(NL)) dut (
        .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir(dir),
        .cap_ab(cap_ab), .cap_ba(cap_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    function automatic logic [HW-1:0] exp_a(int h);
        if (oe_n[h] || dir[h]) return '0;
        return sel_ba[h] ? m_ba[h] : b_in[h*HW +: HW];
    endfunction

    function automatic logic [HW-1:0] exp_b(int h);
        if (oe_n[h] || !dir[h]) return '0;
        return sel_ab[h] ? m_ab[h] : a_in[h*HW +: HW];
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock: update the model, wait for the edge, check half a cycle later.
    task automatic step(string ctx);
        logic [HW-1:0] n_ab [NL];
        logic [HW-1:0] n_ba [NL];
        for (int h = 0; h < NL; h++) begin
            logic [HW-1:0] as, bs;
            as = (!oe_n[h] && !dir[h]) ? exp_a(h) : a_in[h*HW +: HW];
            bs = (!oe_n[h] &&  dir[h]) ? exp_b(h) : b_in[h*HW +: HW];
            n_ab[h] = (cap_ab[h] && !p_ab[h]) ? as : m_ab[h];
            n_ba[h] = (cap_ba[h] && !p_ba[h]) ? bs : m_ba[h];
        end
        @(posedge clk);
        for (int h = 0; h < NL; h++) begin
            if (!rst_n) begin
                m_ab[h] = '0; m_ba[h] = '0; p_ab[h] = 1'b1; p_ba[h] = 1'b1;
            end else begin
                m_ab[h] = n_ab[h]; m_ba[h] = n_ba[h];
                p_ab[h] = cap_ab[h]; p_ba[h] = cap_ba[h];
            end
        end
        @(negedge clk);
        if (rst_n) begin
            for (int h = 0; h < NL; h++) begin
                string mt;
                mt = oe_n[h] ? "R4" : (dir[h] ? "R6" : "R5");
                chk($sformatf("%s R7 %s lane%0d a_oe", ctx, mt, h), 32'(a_oe[h]),
                    32'(!oe_n[h] && !dir[h]));
                chk($sformatf("%s R7 %s lane%0d b_oe", ctx, mt, h), 32'(b_oe[h]),
                    32'(!oe_n[h] && dir[h]));
                chk($sformatf("%s %s R8 lane%0d a_out", ctx, mt, h),
                    32'(a_out[h*HW +: HW]), 32'(exp_a(h)));
                chk($sformatf("%s %s R8 lane%0d b_out", ctx, mt, h),
                    32'(b_out[h*HW +: HW]), 32'(exp_b(h)));
            end
        end
    endtask

    task automatic set_ctl(logic [NL-1:0] o, logic [NL-1:0] d, logic [NL-1:0] ca,
                           logic [NL-1:0] cb, logic [NL-1:0] sa, logic [NL-1:0] sb);
        oe_n = o; dir = d; cap_ab = ca; cap_ba = cb; sel_ab = sa; sel_ba = sb;
    endtask

    initial begin
        #(200000 * 8);
        fails++; total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int h = 0; h < NL; h++) begin
            m_ab[h] = '0; m_ba[h] = '0; p_ab[h] = 1'b1; p_ba[h] = 1'b1;
        end
        rst_n = 1'b0;
        a_in = 16'hA55A; b_in = 16'h3CC3;
        set_ctl(2'b11, 2'b00, 2'b11, 2'b11, 2'b00, 2'b00);
        @(negedge clk);
        step("rst");
        step("rst");
        rst_n = 1'b1;

        // R1: strobes still high after reset: stored outputs stay zero.
        set_ctl(2'b00, 2'b11, 2'b11, 2'b11, 2'b11, 2'b11);
        step("R1 reset");
        chk("R1 stored A-to-B after reset", 32'(b_out), 32'h0);
        set_ctl(2'b00, 2'b00, 2'b11, 2'b11, 2'b11, 2'b11);
        step("R1 reset");
        chk("R1 stored B-to-A after reset", 32'(a_out), 32'h0);

        // R4 R2 R3: capture both directions at once while isolated, replay later.
        set_ctl(2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
        step("R4 iso");
        a_in = 16'h1234; b_in = 16'h5678;
        set_ctl(2'b11, 2'b00, 2'b11, 2'b11, 2'b00, 2'b00);
        step("R4 iso cap");
        a_in = 16'hFFFF; b_in = 16'h0000;
        set_ctl(2'b00, 2'b11, 2'b11, 2'b11, 2'b11, 2'b11);
        step("R2 hold-high");
        chk("R2 replay A-to-B", 32'(b_out), 32'h1234);
        set_ctl(2'b00, 2'b00, 2'b11, 2'b11, 2'b11, 2'b11);
        step("R3 replay");
        chk("R3 replay B-to-A", 32'(a_out), 32'h5678);

        // R9: capture on A while A is driven from stored B; a_in is ignored.
        set_ctl(2'b00, 2'b00, 2'b00, 2'b00, 2'b11, 2'b11);
        step("R9 prep");
        a_in = 16'hDEAD;
        set_ctl(2'b00, 2'b00, 2'b11, 2'b00, 2'b11, 2'b11);
        step("R9 cap");
        set_ctl(2'b00, 2'b11, 2'b00, 2'b00, 2'b11, 2'b11);
        step("R9 show");
        chk("R9 driven value captured", 32'(b_out), 32'h5678);

        // R8: lanes in opposite directions, only lane 1 captures.
        a_in = 16'h9A00; b_in = 16'h00BC;
        set_ctl(2'b00, 2'b10, 2'b10, 2'b00, 2'b00, 2'b00);
        step("R8 split");
        set_ctl(2'b00, 2'b11, 2'b00, 2'b00, 2'b11, 2'b11);
        step("R8 split");
        chk("R8 lane1 loaded, lane0 kept", 32'(b_out), 32'h9A78);

        // Directed sweep of every oe/dir/select combination, then random mix.
        for (int c = 0; c < 16; c++) begin
            a_in = 16'($urandom); b_in = 16'($urandom);
            set_ctl({2{c[3]}}, {2{c[2]}}, 2'b00, 2'b00, {2{c[1]}}, {2{c[0]}});
            step("R5/R6/R4 sweep");
        end
        for (int i = 0; i < 400; i++) begin
            a_in = 16'($urandom); b_in = 16'($urandom);
            set_ctl(2'($urandom), 2'($urandom), 2'($urandom), 2'($urandom),
                    2'($urandom), 2'($urandom));
            step("rand R2/R3/R10");
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule